// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a storage array that two ports share, split into a parameterised number of independent banks. Each port picks a bank with a bank-select field and a word inside that bank with a word index. Both ports may work in the same clock cycle as long as they name different banks. Concurrency is granted per bank, not per word.

When both active ports name the same bank in one cycle, the block does not arbitrate. It voids both accesses: it drops both writes, raises a collision flag on each port and returns a fixed poison word on any read. Every port registers its request at the clock edge. A per-port mode pin picks one of two read paths. The flow-through path delivers data in the cycle after the request is registered. The pipelined path delivers it one register stage later. An output enable masks what the port presents and leaves the internal data stage alone.

Words are 18 bits wide and hold two 9-bit bytes, each with its own write strobe. A port is live only when its active-high enable is 1 and its active-low enable is 0.

Top module: `banked_dpram`

## Requirements
- R1: Synchronous active-high reset clears every registered request and the pipelined stage, so that after reset both ports show read-data 0, valid 0 and collision 0.
- R2: A port whose active-high enable is 0 or whose active-low enable is 1 during a cycle issues no access: it writes nothing, reports no valid read and causes no collision.
- R3: A read registered at one edge returns the word stored at its bank and word index, and a write registered at one edge is visible to a read registered at any later edge.
- R4: With the mode pin at 1 (pipelined), read data and valid appear one clock edge later than with the mode pin at 0 (flow-through, shown just after the registering edge).
- R5: Byte strobe bit 0 guards data bits 8:0 and strobe bit 1 guards bits 17:9, and a write changes only the guarded bits.
- R6: Accesses by the two ports to different banks in the same cycle both complete, including two writes, or a read on each port.
- R7: When both ports are live and name the same bank in one cycle, both collision flags are 1 for that access, neither port reports valid, and a reading port returns the poison word (default 18'h2DEAD) while a writing port returns 0.
- R8: Writes issued during a same-bank collision are discarded, and the words they addressed keep their earlier contents.
- R9: With output enable at 0 a port shows read-data 0 and valid 0 at once. Raising it again in the same cycle shows the held result, because the pipelined stage is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_ce0 | input | 1 | Port A enable, active high |
| a_ce1_n | input | 1 | Port A enable, active low |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_bank | input | BANK_W | Port A bank select |
| a_addr | input | ADDR_W | Port A word index in the bank |
| a_wdata | input | 18 | Port A write data |
| a_be | input | 2 | Port A byte write strobes |
| a_oe | input | 1 | Port A output enable |
| a_pipe | input | 1 | Port A mode: 1 pipelined, 0 flow-through |
| a_rdata | output | 18 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| a_clash | output | 1 | Port A collision flag |
| b_ce0 | input | 1 | Port B enable, active high |
| b_ce1_n | input | 1 | Port B enable, active low |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_bank | input | BANK_W | Port B bank select |
| b_addr | input | ADDR_W | Port B word index in the bank |
| b_wdata | input | 18 | Port B write data |
| b_be | input | 2 | Port B byte write strobes |
| b_oe | input | 1 | Port B output enable |
| b_pipe | input | 1 | Port B mode: 1 pipelined, 0 flow-through |
| b_rdata | output | 18 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_clash | output | 1 | Port B collision flag |

## Verification
In flow-through mode a request driven before an edge yields its data, valid and collision outputs just after that same edge, so the vector walk samples one time step past each rising edge. In pipelined mode the result is due one edge later, and the bench inserts an idle cycle and samples after the second edge. A write lands at the edge after it is registered, so each read-back vector trails its write by at least one step. The output-enable mask is combinational: the bench samples with the mask low and then with it high inside one cycle, before the next edge can move the pipelined stage.

// File: rtl/bkdp_pkg.sv
package bkdp_pkg;

    localparam int DATA_W = 18;
    localparam int BYTE_W = 9;
    localparam int NBYTE  = DATA_W / BYTE_W;
    localparam int NPORT  = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NBYTE-1:0]  strobe_t;

    // One port's result as it leaves the read path
    typedef struct packed {
        logic  valid;
        logic  clash;
        word_t data;
    } rsp_t;

    // Port is live only with the high enable set and the low enable clear
    function automatic logic port_live(input logic en_hi, input logic en_lo_n);
        return en_hi & ~en_lo_n;
    endfunction

    // Replace only the strobed bytes of a stored word
    function automatic word_t merge_bytes(input word_t old_w, input word_t new_w,
                                          input strobe_t be);
        word_t res;
        res = old_w;
        for (int k = 0; k < NBYTE; k++) begin
            if (be[k]) res[k*BYTE_W +: BYTE_W] = new_w[k*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/bkdp_port_in.sv
module bkdp_port_in
    import bkdp_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce0,
    input  logic              ce1_n,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  strobe_t           be,
    output logic              act_q,
    output logic              we_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] addr_q,
    output word_t             wdata_q,
    output strobe_t           be_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            we_q    <= 1'b0;
            bank_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            act_q   <= port_live(ce0, ce1_n);
            we_q    <= we;
            bank_q  <= bank;
            addr_q  <= addr;
            wdata_q <= wdata;
            be_q    <= be;
        end
    end

endmodule

// File: rtl/bkdp_bank_guard.sv
module bkdp_bank_guard
    import bkdp_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [NPORT-1:0]             act,
    input  logic [NPORT-1:0][BANK_W-1:0] bank,
    output logic                         clash
);

    // Same bank named by two live ports voids both accesses
    always_comb begin
        clash = act[0] & act[1] & (bank[0] == bank[1]);
    end

endmodule

// File: rtl/bkdp_array.sv
module bkdp_array
    import bkdp_pkg::*;
#(
    parameter int BANKS  = 8,
    parameter int WORDS  = 16,
    parameter int BANK_W = 3,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic [NPORT-1:0]             act,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][BANK_W-1:0] bank,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  word_t [NPORT-1:0]            wdata,
    input  strobe_t [NPORT-1:0]          be,
    input  logic                         clash,
    output word_t [NPORT-1:0]            rword
);

    word_t bank_rd [BANKS][NPORT];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        word_t cells [WORDS];

        // At most one port can hit a bank once clashes are dropped
        always_ff @(posedge clk) begin
            for (int p = 0; p < NPORT; p++) begin
                if (act[p] && we[p] && !clash && bank[p] == BANK_W'(b)) begin
                    cells[addr[p]] <= merge_bytes(cells[addr[p]], wdata[p], be[p]);
                end
            end
        end

        for (genvar p = 0; p < NPORT; p++) begin : g_rd
            assign bank_rd[b][p] = cells[addr[p]];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rword[p] = bank_rd[bank[p]][p];
        end
    end

endmodule

// File: rtl/bkdp_port_out.sv
module bkdp_port_out
    import bkdp_pkg::*;
#(
    parameter word_t POISON = 18'h2DEAD
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pipe,
    input  logic  oe,
    input  logic  act_q,
    input  logic  we_q,
    input  logic  clash,
    input  word_t rword,
    output word_t rdata,
    output logic  rvalid,
    output logic  clash_o
);

    rsp_t flow_r;
    rsp_t pipe_q;
    rsp_t pick;
    logic rd_op;

    always_comb begin
        rd_op        = act_q & ~we_q;
        flow_r.clash = clash;
        flow_r.valid = rd_op & ~clash;
        if (!rd_op)     flow_r.data = '0;
        else if (clash) flow_r.data = POISON;
        else            flow_r.data = rword;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= flow_r;
    end

    // Mode picks the stage; the enable masks only what is shown
    always_comb begin
        pick    = pipe ? pipe_q : flow_r;
        rdata   = oe ? pick.data : '0;
        rvalid  = oe & pick.valid;
        clash_o = pick.clash;
    end

endmodule

// File: rtl/banked_dpram.sv
module banked_dpram
    import bkdp_pkg::*;
#(
    parameter int    BANKS  = 8,
    parameter int    WORDS  = 16,
    parameter word_t POISON = 18'h2DEAD,
    localparam int   BANK_W = $clog2(BANKS),
    localparam int   ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_ce0,
    input  logic              a_ce1_n,
    input  logic              a_we,
    input  logic [BANK_W-1:0] a_bank,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [17:0]       a_wdata,
    input  logic [1:0]        a_be,
    input  logic              a_oe,
    input  logic              a_pipe,
    output logic [17:0]       a_rdata,
    output logic              a_rvalid,
    output logic              a_clash,
    input  logic              b_ce0,
    input  logic              b_ce1_n,
    input  logic              b_we,
    input  logic [BANK_W-1:0] b_bank,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [17:0]       b_wdata,
    input  logic [1:0]        b_be,
    input  logic              b_oe,
    input  logic              b_pipe,
    output logic [17:0]       b_rdata,
    output logic              b_rvalid,
    output logic              b_clash
);

    // Port-indexed views of the pins
    logic [NPORT-1:0]             in_ce0, in_ce1_n, in_we, in_oe, in_pipe;
    logic [NPORT-1:0][BANK_W-1:0] in_bank;
    logic [NPORT-1:0][ADDR_W-1:0] in_addr;
    word_t [NPORT-1:0]            in_wdata;
    strobe_t [NPORT-1:0]          in_be;

    assign in_ce0   = {b_ce0, a_ce0};
    assign in_ce1_n = {b_ce1_n, a_ce1_n};
    assign in_we    = {b_we, a_we};
    assign in_oe    = {b_oe, a_oe};
    assign in_pipe  = {b_pipe, a_pipe};
    assign in_bank  = {b_bank, a_bank};
    assign in_addr  = {b_addr, a_addr};
    assign in_wdata = {b_wdata, a_wdata};
    assign in_be    = {b_be, a_be};

    // Registered requests
    logic [NPORT-1:0]             r_act, r_we;
    logic [NPORT-1:0][BANK_W-1:0] r_bank;
    logic [NPORT-1:0][ADDR_W-1:0] r_addr;
    word_t [NPORT-1:0]            r_wdata;
    strobe_t [NPORT-1:0]          r_be;

    logic                         clash;
    word_t [NPORT-1:0]            rword;
    word_t [NPORT-1:0]            out_rdata;
    logic [NPORT-1:0]             out_rvalid, out_clash;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bkdp_port_in #(
            .BANK_W (BANK_W),
            .ADDR_W (ADDR_W)
        ) u_in (
            .clk     (clk),
            .rst     (rst),
            .ce0     (in_ce0[p]),
            .ce1_n   (in_ce1_n[p]),
            .we      (in_we[p]),
            .bank    (in_bank[p]),
            .addr    (in_addr[p]),
            .wdata   (in_wdata[p]),
            .be      (in_be[p]),
            .act_q   (r_act[p]),
            .we_q    (r_we[p]),
            .bank_q  (r_bank[p]),
            .addr_q  (r_addr[p]),
            .wdata_q (r_wdata[p]),
            .be_q    (r_be[p])
        );

        bkdp_port_out #(
            .POISON (POISON)
        ) u_out (
            .clk     (clk),
            .rst     (rst),
            .pipe    (in_pipe[p]),
            .oe      (in_oe[p]),
            .act_q   (r_act[p]),
            .we_q    (r_we[p]),
            .clash   (clash),
            .rword   (rword[p]),
            .rdata   (out_rdata[p]),
            .rvalid  (out_rvalid[p]),
            .clash_o (out_clash[p])
        );
    end

    bkdp_bank_guard #(
        .BANK_W (BANK_W)
    ) u_guard (
        .act   (r_act),
        .bank  (r_bank),
        .clash (clash)
    );

    bkdp_array #(
        .BANKS  (BANKS),
        .WORDS  (WORDS),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .act   (r_act),
        .we    (r_we),
        .bank  (r_bank),
        .addr  (r_addr),
        .wdata (r_wdata),
        .be    (r_be),
        .clash (clash),
        .rword (rword)
    );

    assign a_rdata  = out_rdata[0];
    assign a_rvalid = out_rvalid[0];
    assign a_clash  = out_clash[0];
    assign b_rdata  = out_rdata[1];
    assign b_rvalid = out_rvalid[1];
    assign b_clash  = out_clash[1];

endmodule

// File: rtl/bkdp_checker.sv
module bkdp_checker (
    input logic        clk,
    input logic        rst,
    input logic        a_ce0,
    input logic        a_ce1_n,
    input logic        a_oe,
    input logic        a_pipe,
    input logic [17:0] a_rdata,
    input logic        a_rvalid,
    input logic        a_clash,
    input logic        b_ce0,
    input logic        b_ce1_n,
    input logic        b_oe,
    input logic        b_pipe,
    input logic [17:0] b_rdata,
    input logic        b_rvalid,
    input logic        b_clash
);

    // R1: the first cycle out of reset shows nothing on either port
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_rvalid && !b_rvalid && !a_clash && !b_clash));

    // R2: a port that was not live at the last edge gives no flow result
    a_r2_idle_port_a: assert property (@(posedge clk) disable iff (rst)
        (!a_pipe && !$past(rst) && !$past(a_ce0 && !a_ce1_n)) |-> (!a_rvalid && !a_clash));
    a_r2_idle_port_b: assert property (@(posedge clk) disable iff (rst)
        (!b_pipe && !$past(rst) && !$past(b_ce0 && !b_ce1_n)) |-> (!b_rvalid && !b_clash));

    // R7: a collision never reports valid data
    a_r7_no_valid_a: assert property (@(posedge clk) disable iff (rst)
        a_clash |-> !a_rvalid);
    a_r7_no_valid_b: assert property (@(posedge clk) disable iff (rst)
        b_clash |-> !b_rvalid);

    // R7: with equal modes both ports see the same collision
    a_r7_flag_pair: assert property (@(posedge clk) disable iff (rst)
        (a_pipe == b_pipe) |-> (a_clash == b_clash));

    // R9: a masked port shows zero data and no valid
    a_r9_mask_a: assert property (@(posedge clk) disable iff (rst)
        !a_oe |-> (a_rdata == 18'h0 && !a_rvalid));
    a_r9_mask_b: assert property (@(posedge clk) disable iff (rst)
        !b_oe |-> (b_rdata == 18'h0 && !b_rvalid));

endmodule

bind banked_dpram bkdp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_ce0    (a_ce0),
    .a_ce1_n  (a_ce1_n),
    .a_oe     (a_oe),
    .a_pipe   (a_pipe),
    .a_rdata  (a_rdata),
    .a_rvalid (a_rvalid),
    .a_clash  (a_clash),
    .b_ce0    (b_ce0),
    .b_ce1_n  (b_ce1_n),
    .b_oe     (b_oe),
    .b_pipe   (b_pipe),
    .b_rdata  (b_rdata),
    .b_rvalid (b_rvalid),
    .b_clash  (b_clash)
);

// File: tb/sim_banked_dpram.sv
module sim_banked_dpram;

    localparam int          PERIOD = 10;
    localparam logic [17:0] POISON = 18'h2DEAD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_ce0 = 0, a_ce1_n = 0, a_we = 0, a_oe = 1, a_pipe = 0;
    logic [2:0]  a_bank = 0;
    logic [3:0]  a_addr = 0;
    logic [17:0] a_wdata = 0;
    logic [1:0]  a_be = 0;
    logic        b_ce0 = 0, b_ce1_n = 0, b_we = 0, b_oe = 1, b_pipe = 0;
    logic [2:0]  b_bank = 0;
    logic [3:0]  b_addr = 0;
    logic [17:0] b_wdata = 0;
    logic [1:0]  b_be = 0;
    logic [17:0] a_rdata, b_rdata;
    logic        a_rvalid, a_clash, b_rvalid, b_clash;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    banked_dpram #(.BANKS(8), .WORDS(16), .POISON(POISON)) u0 (.*);

    typedef struct packed {
        logic        en;
        logic        we;
        logic [2:0]  bank;
        logic [3:0]  addr;
        logic [17:0] data;
        logic [1:0]  be;
    } op_t;

    typedef struct packed {
        logic        valid;
        logic        clash;
        logic [17:0] data;
    } ex_t;

    typedef struct packed {
        op_t a;
        op_t b;
        ex_t xa;
        ex_t xb;
    } vec_t;

    function automatic op_t wr(input logic [2:0] bk, input logic [3:0] ad,
                               input logic [17:0] d, input logic [1:0] be);
        return '{en: 1'b1, we: 1'b1, bank: bk, addr: ad, data: d, be: be};
    endfunction
    function automatic op_t rd(input logic [2:0] bk, input logic [3:0] ad);
        return '{en: 1'b1, we: 1'b0, bank: bk, addr: ad, data: 18'h0, be: 2'b00};
    endfunction
    function automatic op_t nop();
        return '0;
    endfunction
    function automatic ex_t ok(input logic [17:0] d);
        return '{valid: 1'b1, clash: 1'b0, data: d};
    endfunction
    function automatic ex_t hit(input logic [17:0] d);
        return '{valid: 1'b0, clash: 1'b1, data: d};
    endfunction
    function automatic ex_t none();
        return '0;
    endfunction

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{wr(3'd1, 4'd3, 18'h12345, 2'b11), wr(3'd2, 4'd5, 18'h0ABCD, 2'b11), none(), none()},
        '{rd(3'd2, 4'd5), rd(3'd1, 4'd3), ok(18'h0ABCD), ok(18'h12345)},
        '{wr(3'd1, 4'd3, 18'h3FFFF, 2'b01), nop(), none(), none()},
        '{rd(3'd1, 4'd3), nop(), ok(18'h123FF), none()},
        '{wr(3'd1, 4'd3, 18'h00000, 2'b10), nop(), none(), none()},
        '{nop(), rd(3'd1, 4'd3), none(), ok(18'h001FF)},
        '{wr(3'd4, 4'd0, 18'h00AAA, 2'b11), nop(), none(), none()},
        '{nop(), wr(3'd4, 4'd9, 18'h00BBB, 2'b11), none(), none()},
        '{wr(3'd4, 4'd0, 18'h11111, 2'b11), wr(3'd4, 4'd9, 18'h22222, 2'b11), hit(18'h0), hit(18'h0)},
        '{rd(3'd4, 4'd0), rd(3'd4, 4'd9), hit(POISON), hit(POISON)},
        '{rd(3'd4, 4'd0), nop(), ok(18'h00AAA), none()},
        '{nop(), rd(3'd4, 4'd9), none(), ok(18'h00BBB)},
        '{'{en: 1'b0, we: 1'b1, bank: 3'd1, addr: 4'd3, data: 18'h15555, be: 2'b11},
          rd(3'd1, 4'd3), none(), ok(18'h001FF)},
        '{'{en: 1'b0, we: 1'b0, bank: 3'd7, addr: 4'd15, data: 18'h0, be: 2'b00},
          nop(), none(), none()},
        '{wr(3'd7, 4'd15, 18'h2FFFF, 2'b11), wr(3'd0, 4'd0, 18'h3C00F, 2'b11), none(), none()},
        '{rd(3'd7, 4'd15), rd(3'd0, 4'd0), ok(18'h2FFFF), ok(18'h3C00F)},
        '{rd(3'd2, 4'd5), wr(3'd2, 4'd0, 18'h01234, 2'b11), hit(POISON), hit(18'h0)},
        '{rd(3'd2, 4'd5), nop(), ok(18'h0ABCD), none()}
    };

    // Requirement tags for each table row
    function automatic string vtag(input int i);
        case (i)
            0, 1, 14, 15: return "R3/R6";
            2, 3, 4, 5:   return "R5";
            6, 7, 10, 11: return "R8";
            8, 9, 16:     return "R7/R8";
            12, 13:       return "R2";
            default:      return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h (valid,clash,data)", req, got, exp);
        end
    endtask

    task automatic drive_a(input op_t o);
        a_ce0 = o.en; a_ce1_n = 1'b0; a_we = o.we; a_bank = o.bank;
        a_addr = o.addr; a_wdata = o.data; a_be = o.be;
    endtask
    task automatic drive_b(input op_t o);
        b_ce0 = o.en; b_ce1_n = 1'b0; b_we = o.we; b_bank = o.bank;
        b_addr = o.addr; b_wdata = o.data; b_be = o.be;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        check("R1 reset", {a_rvalid, a_clash, a_rdata}, 20'h0);
        check("R1 reset", {b_rvalid, b_clash, b_rdata}, 20'h0);
        @(negedge clk);
        rst = 1'b0;

        // Table walk, both ports flow-through, results due just after the edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive_a(VECS[i].a);
            drive_b(VECS[i].b);
            tick();
            check($sformatf("%s vec%0d A", vtag(i), i), {a_rvalid, a_clash, a_rdata}, VECS[i].xa);
            check($sformatf("%s vec%0d B", vtag(i), i), {b_rvalid, b_clash, b_rdata}, VECS[i].xb);
        end
        @(negedge clk);
        drive_a(nop());
        drive_b(nop());

        // R2: active-low enable held high blocks a write
        @(negedge clk);
        drive_a(wr(3'd1, 4'd3, 18'h00007, 2'b11));
        a_ce1_n = 1'b1;
        tick();
        check("R2 ce1_n write", {a_rvalid, a_clash, a_rdata}, 20'h0);
        @(negedge clk);
        drive_a(rd(3'd1, 4'd3));
        tick();
        check("R2 ce1_n readback", {a_rvalid, a_clash, a_rdata}, {2'b10, 18'h001FF});

        // R4: pipelined mode delays the result by one edge
        @(negedge clk);
        drive_a(nop());
        tick();
        @(negedge clk);
        a_pipe = 1'b1;
        drive_a(rd(3'd2, 4'd5));
        tick();
        check("R4 pipe not yet", {a_rvalid, a_clash, a_rdata}, 20'h0);
        @(negedge clk);
        drive_a(nop());
        tick();
        check("R4 pipe due", {a_rvalid, a_clash, a_rdata}, {2'b10, 18'h0ABCD});

        // R9: mask in pipelined mode, stage kept
        @(negedge clk);
        drive_a(rd(3'd2, 4'd5));
        tick();
        @(negedge clk);
        drive_a(nop());
        a_oe = 1'b0;
        tick();
        check("R9 masked pipe", {a_rvalid, a_clash, a_rdata}, 20'h0);
        a_oe = 1'b1;
        #1;
        check("R9 unmasked pipe", {a_rvalid, a_clash, a_rdata}, {2'b10, 18'h0ABCD});

        // R9: mask in flow-through mode
        @(negedge clk);
        a_pipe = 1'b0;
        drive_a(rd(3'd7, 4'd15));
        a_oe = 1'b0;
        tick();
        check("R9 masked flow", {a_rvalid, a_clash, a_rdata}, 20'h0);
        a_oe = 1'b1;
        #1;
        check("R9 unmasked flow", {a_rvalid, a_clash, a_rdata}, {2'b10, 18'h2FFFF});

        // R1: reset mid-traffic clears the registered request
        @(negedge clk);
        drive_a(rd(3'd2, 4'd5));
        rst = 1'b1;
        tick();
        check("R1 mid reset A", {a_rvalid, a_clash, a_rdata}, 20'h0);
        check("R1 mid reset B", {b_rvalid, b_clash, b_rdata}, 20'h0);
        @(negedge clk);
        rst = 1'b0;
        drive_a(nop());
        tick();

        finish_run();
    end

endmodule